// File: doc/BRIEF.md
# Per-Byte Race Metadata Permission Tracker

This block holds the race-detection metadata for every byte of one cached line. Each byte has a 16-bit word with three parts: a 4-bit code that combines how much of the access history is still held on chip (the status) with what the local thread may do without a check (the permission), a 6-bit clock of the last local read and a 6-bit clock of the last local write. The word changes on five kinds of input: fill-time grants built from happens-before results, eviction notices for the metadata, remote reads and writes seen through coherence, and local accesses.

A local access is checked against the byte's permission. One cycle later the block reports either that the filter lets the access through or that a hardware race check is needed. There is no back-pressure on this path. The request side has no ready signal and is accepted on every cycle in which it is valid. The response is a one-cycle valid pulse that the consumer cannot stall. The event inputs have no ready either; each is taken on the cycle it is valid. A separate combinational path maps a data address to its metadata address. Every byte's stored word can be read out through a combinational view port.

Top module: `race_meta_tracker`

## Requirements
- R1: After reset every byte reads 16'h9000. The layout is code in [15:12], read clock in [11:6] and write clock in [5:0]. Code 9 means InSoftware with None and both clocks are zero.
- R2: The code equals status×3 + permission. Status values are LastWrite=0, AllLastReads=1, Everything=2, InSoftware=3. Permission values are None=0, Read=1, Write=2. A stored code is never 12 to 15, and such a code would be read as InSoftware with None.
- R3: A fill sets the byte's status and both clocks from the fill inputs and grants a permission. The grant is Write when the thread is after the last write and after all last reads. It is Read when the thread is after the last write only. Otherwise it is None.
- R4: A fill grants Write only when the status is Everything. It grants Read only when the status is Everything or LastWrite. In every other case, including AllLastReads and InSoftware, the grant is None.
- R5: Evicting a write clock moves Everything to AllLastReads and LastWrite to InSoftware. Evicting a read clock moves Everything to LastWrite and AllLastReads to InSoftware. Every other eviction leaves the status as it was, and evictions never change the permission.
- R6: A remote write sets the permission to None. A remote read lowers Write to Read and leaves Read and None alone. Only a fill can raise a permission.
- R7: A local write sets the status to Everything and stores the access clock as the write clock. A local read stores the access clock as the read clock. Both happen whether the filter passes or not.
- R8: A read passes the filter with Read or Write permission. A write passes only with Write. When the filter does not pass, the response raises a check request instead of pass.
- R9: When several events hit one byte in the same cycle, they apply in this order: fill, then eviction, then remote event, then local access. The filter sees the permission after the remote event.
- R10: The metadata address is md_base + 2×md_data_addr, taken modulo 2^AW.
- R11: Each accepted local access gives exactly one response on the next cycle: resp_valid=1 with exactly one of resp_pass and resp_check set. resp_valid is 0 on cycles that follow no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local access request |
| acc_write | input | 1 | 1 = local write, 0 = local read |
| acc_byte | input | IW | Byte index of the access |
| acc_clock | input | CW | Local logical clock of the access |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_pass | output | 1 | Permission filter passed |
| resp_check | output | 1 | Hardware race check requested |
| rmt_valid | input | 1 | Remote access seen through coherence |
| rmt_write | input | 1 | 1 = remote write, 0 = remote read |
| rmt_byte | input | IW | Byte index of the remote access |
| evc_valid | input | 1 | Metadata eviction notice |
| evc_write | input | 1 | 1 = write clock evicted, 0 = read clock evicted |
| evc_byte | input | IW | Byte index of the eviction |
| fill_valid | input | 1 | Fill-time grant |
| fill_byte | input | IW | Byte index of the fill |
| fill_status | input | 2 | Status at fill (R2 encoding) |
| fill_after_wr | input | 1 | Thread is after the last write |
| fill_after_rd | input | 1 | Thread is after all last reads |
| fill_rd_clock | input | CW | Read clock loaded at fill |
| fill_wr_clock | input | CW | Write clock loaded at fill |
| view_byte | input | IW | Byte selected for view |
| view_meta | output | MW | Stored metadata word of the selected byte |
| md_base | input | AW | Base of the metadata region |
| md_data_addr | input | AW | Data byte address |
| md_addr | output | AW | Metadata address |

## Verification
Fills are applied with each status and each pair of happens-before flags. This separates the Write, Read and None grants and shows where a weak status caps the grant. Eviction sequences are driven from each starting status, including evictions that must change nothing, so the status state machine is checked on its own apart from the permission. Remote read and write patterns, repeated and mixed, show that the permission only ever drops. Single-event local accesses are compared with accesses that arrive in the same cycle as a fill, an eviction and a remote event, which shows the order in which these are applied.

// File: rtl/race_meta_pkg.sv
package race_meta_pkg;

  typedef enum logic [1:0] {
    ST_LAST_WR = 2'd0,
    ST_ALL_RD  = 2'd1,
    ST_FULL    = 2'd2,
    ST_SOFT    = 2'd3
  } hw_status_e;

  typedef enum logic [1:0] {
    PM_NONE  = 2'd0,
    PM_READ  = 2'd1,
    PM_WRITE = 2'd2
  } perm_e;

  localparam int unsigned CODE_W = 4;

  function automatic logic [CODE_W-1:0] pack_code(hw_status_e s, perm_e p);
    return {2'b00, s} * 4'd3 + {2'b00, p};
  endfunction

  function automatic hw_status_e code_status(logic [CODE_W-1:0] c);
    if (c < 4'd3)      return ST_LAST_WR;
    else if (c < 4'd6) return ST_ALL_RD;
    else if (c < 4'd9) return ST_FULL;
    else               return ST_SOFT;
  endfunction

  function automatic perm_e code_perm(logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] base;
    if (c >= 4'd12) return PM_NONE;
    base = {2'b00, code_status(c)} * 4'd3;
    return perm_e'(2'(c - base));
  endfunction

endpackage

// File: rtl/rmt_fill_grant.sv
module rmt_fill_grant
  import race_meta_pkg::*;
(
  input  hw_status_e status,
  input  logic       after_wr,
  input  logic       after_rd,
  output perm_e      grant
);
  logic knows_wr, knows_all;

  assign knows_all = (status == ST_FULL);
  assign knows_wr  = (status == ST_FULL) || (status == ST_LAST_WR);

  always_comb begin
    if (knows_all && after_wr && after_rd) grant = PM_WRITE;
    else if (knows_wr && after_wr)         grant = PM_READ;
    else                                   grant = PM_NONE;
  end
endmodule

// File: rtl/rmt_perm_filter.sv
module rmt_perm_filter
  import race_meta_pkg::*;
(
  input  perm_e perm,
  input  logic  is_write,
  output logic  pass,
  output logic  need_check
);
  always_comb begin
    if (is_write) pass = (perm == PM_WRITE);
    else          pass = (perm == PM_WRITE) || (perm == PM_READ);
    need_check = !pass;
  end
endmodule

// File: rtl/rmt_byte_cell.sv
module rmt_byte_cell
  import race_meta_pkg::*;
#(
  parameter int unsigned CW = 6,
  localparam int unsigned MW = CODE_W + 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_hit,
  input  hw_status_e    fill_status,
  input  perm_e         fill_perm,
  input  logic [CW-1:0] fill_rd,
  input  logic [CW-1:0] fill_wr,
  input  logic          evc_hit,
  input  logic          evc_wr,
  input  logic          rmt_hit,
  input  logic          rmt_wr,
  input  logic          acc_hit,
  input  logic          acc_wr,
  input  logic [CW-1:0] acc_clk,
  output perm_e         perm_mid,
  output logic [MW-1:0] meta_q
);
  localparam logic [MW-1:0] RESET_WORD = {4'd9, {(2*CW){1'b0}}};

  hw_status_e    cur_st, st;
  perm_e         cur_pm, pm;
  logic [CW-1:0] rc, wc;
  logic [MW-1:0] meta_d;
  logic [CODE_W-1:0] code_q;
  logic [1:0]    pm_raw;

  assign code_q = meta_q[MW-1 -: CODE_W];
  assign cur_st = code_status(code_q);
  assign cur_pm = code_perm(code_q);
  assign pm_raw = cur_pm;

  always_comb begin
    st = cur_st;
    pm = cur_pm;
    rc = meta_q[2*CW-1:CW];
    wc = meta_q[CW-1:0];
    // stage 1: fill replaces the entry
    if (fill_hit) begin
      st = fill_status;
      pm = fill_perm;
      rc = fill_rd;
      wc = fill_wr;
    end
    // stage 2: eviction demotes the status
    if (evc_hit) begin
      if (evc_wr) begin
        if (st == ST_FULL)         st = ST_ALL_RD;
        else if (st == ST_LAST_WR) st = ST_SOFT;
      end else begin
        if (st == ST_FULL)         st = ST_LAST_WR;
        else if (st == ST_ALL_RD)  st = ST_SOFT;
      end
    end
    // stage 3: remote access lowers the permission
    if (rmt_hit) begin
      if (rmt_wr)                pm = PM_NONE;
      else if (pm == PM_WRITE)   pm = PM_READ;
    end
    perm_mid = pm;
    // stage 4: local access records its clock
    if (acc_hit) begin
      if (acc_wr) begin
        wc = acc_clk;
        st = ST_FULL;
      end else begin
        rc = acc_clk;
      end
    end
    meta_d = {pack_code(st, pm), rc, wc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) meta_q <= RESET_WORD;
    else        meta_q <= meta_d;
  end

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q < 4'd12);

  // R6
  perm_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_hit |=> pm_raw <= $past(pm_raw));

  // R6
  rmt_wr_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_hit && rmt_wr |=> cur_pm == PM_NONE);

  // R7
  wr_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit && acc_wr |=> cur_st == ST_FULL);

endmodule

// File: rtl/rmt_md_addr.sv
module rmt_md_addr #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] data_addr,
  output logic [AW-1:0] md_addr
);
  assign md_addr = base + (data_addr << 1);
endmodule

// File: rtl/race_meta_tracker.sv
module race_meta_tracker
  import race_meta_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned CW = 6,
  parameter int unsigned AW = 32,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned MW = CODE_W + 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [IW-1:0] acc_byte,
  input  logic [CW-1:0] acc_clock,
  output logic          resp_valid,
  output logic          resp_pass,
  output logic          resp_check,
  input  logic          rmt_valid,
  input  logic          rmt_write,
  input  logic [IW-1:0] rmt_byte,
  input  logic          evc_valid,
  input  logic          evc_write,
  input  logic [IW-1:0] evc_byte,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_byte,
  input  logic [1:0]    fill_status,
  input  logic          fill_after_wr,
  input  logic          fill_after_rd,
  input  logic [CW-1:0] fill_rd_clock,
  input  logic [CW-1:0] fill_wr_clock,
  input  logic [IW-1:0] view_byte,
  output logic [MW-1:0] view_meta,
  input  logic [AW-1:0] md_base,
  input  logic [AW-1:0] md_data_addr,
  output logic [AW-1:0] md_addr
);
  hw_status_e    fill_st;
  perm_e         fill_grant;
  perm_e         mid_pm [NB];
  logic [MW-1:0] meta_arr [NB];
  perm_e         sel_pm;
  logic          flt_pass, flt_check;

  assign fill_st = hw_status_e'(fill_status);

  rmt_fill_grant u_grant (
    .status   (fill_st),
    .after_wr (fill_after_wr),
    .after_rd (fill_after_rd),
    .grant    (fill_grant)
  );

  for (genvar gi = 0; gi < NB; gi++) begin : g_cell
    rmt_byte_cell #(.CW(CW)) u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_hit    (fill_valid && (fill_byte == IW'(gi))),
      .fill_status (fill_st),
      .fill_perm   (fill_grant),
      .fill_rd     (fill_rd_clock),
      .fill_wr     (fill_wr_clock),
      .evc_hit     (evc_valid && (evc_byte == IW'(gi))),
      .evc_wr      (evc_write),
      .rmt_hit     (rmt_valid && (rmt_byte == IW'(gi))),
      .rmt_wr      (rmt_write),
      .acc_hit     (acc_valid && (acc_byte == IW'(gi))),
      .acc_wr      (acc_write),
      .acc_clk     (acc_clock),
      .perm_mid    (mid_pm[gi]),
      .meta_q      (meta_arr[gi])
    );
  end

  assign sel_pm    = mid_pm[acc_byte];
  assign view_meta = meta_arr[view_byte];

  rmt_perm_filter u_filter (
    .perm       (sel_pm),
    .is_write   (acc_write),
    .pass       (flt_pass),
    .need_check (flt_check)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_pass  <= 1'b0;
      resp_check <= 1'b0;
    end else begin
      resp_valid <= acc_valid;
      resp_pass  <= acc_valid && flt_pass;
      resp_check <= acc_valid && flt_check;
    end
  end

  rmt_md_addr #(.AW(AW)) u_addr (
    .base      (md_base),
    .data_addr (md_data_addr),
    .md_addr   (md_addr)
  );

  // R11
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);

  // R11
  resp_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_pass, resp_check}) == 1);

  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !resp_valid && !resp_pass && !resp_check);

endmodule

// File: tb/sim_race_meta_tracker.sv
module sim_race_meta_tracker;
  localparam int NB = 8;
  localparam int CW = 6;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int MW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic acc_valid, acc_write;
  logic [IW-1:0] acc_byte;
  logic [CW-1:0] acc_clock;
  logic resp_valid, resp_pass, resp_check;
  logic rmt_valid, rmt_write;
  logic [IW-1:0] rmt_byte;
  logic evc_valid, evc_write;
  logic [IW-1:0] evc_byte;
  logic fill_valid, fill_after_wr, fill_after_rd;
  logic [IW-1:0] fill_byte;
  logic [1:0] fill_status;
  logic [CW-1:0] fill_rd_clock, fill_wr_clock;
  logic [IW-1:0] view_byte;
  logic [MW-1:0] view_meta;
  logic [AW-1:0] md_base, md_data_addr, md_addr;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  race_meta_tracker #(.NB(NB), .CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_byte(acc_byte), .acc_clock(acc_clock),
    .resp_valid(resp_valid), .resp_pass(resp_pass), .resp_check(resp_check),
    .rmt_valid(rmt_valid), .rmt_write(rmt_write), .rmt_byte(rmt_byte),
    .evc_valid(evc_valid), .evc_write(evc_write), .evc_byte(evc_byte),
    .fill_valid(fill_valid), .fill_byte(fill_byte), .fill_status(fill_status),
    .fill_after_wr(fill_after_wr), .fill_after_rd(fill_after_rd),
    .fill_rd_clock(fill_rd_clock), .fill_wr_clock(fill_wr_clock),
    .view_byte(view_byte), .view_meta(view_meta),
    .md_base(md_base), .md_data_addr(md_data_addr), .md_addr(md_addr)
  );

  // status: LastWrite=0 AllLastReads=1 Everything=2 InSoftware=3; perm: None=0 Read=1 Write=2
  function automatic logic [15:0] word(int st, int pm, int rc, int wc);
    return {4'(st * 3 + pm), 6'(rc), 6'(wc)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic see(int b, string tag, logic [15:0] exp);
    view_byte = IW'(b);
    #1;
    chk(tag, 32'(view_meta), 32'(exp));
  endtask

  task automatic clear_in();
    acc_valid = 0; acc_write = 0; acc_byte = 0; acc_clock = 0;
    rmt_valid = 0; rmt_write = 0; rmt_byte = 0;
    evc_valid = 0; evc_write = 0; evc_byte = 0;
    fill_valid = 0; fill_byte = 0; fill_status = 0;
    fill_after_wr = 0; fill_after_rd = 0; fill_rd_clock = 0; fill_wr_clock = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic set_fill(int b, int st, bit aw, bit ar, int rc, int wc);
    fill_valid = 1; fill_byte = IW'(b); fill_status = 2'(st);
    fill_after_wr = aw; fill_after_rd = ar;
    fill_rd_clock = CW'(rc); fill_wr_clock = CW'(wc);
  endtask

  task automatic set_evc(int b, bit w);
    evc_valid = 1; evc_byte = IW'(b); evc_write = w;
  endtask

  task automatic set_rmt(int b, bit w);
    rmt_valid = 1; rmt_byte = IW'(b); rmt_write = w;
  endtask

  task automatic set_acc(int b, bit w, int c);
    acc_valid = 1; acc_byte = IW'(b); acc_write = w; acc_clock = CW'(c);
  endtask

  task automatic chk_resp(string tag, bit pass);
    chk({tag, " valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " pass"}, 32'(resp_pass), 32'(pass));
    chk({tag, " check"}, 32'(resp_check), 32'(!pass));
  endtask

  task automatic t_reset();
    for (int b = 0; b < NB; b++) see(b, "R1 reset word", 16'h9000);
    chk("R11 no resp after reset", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_fill();
    set_fill(0, 2, 1, 1, 5, 3); tick(); see(0, "R3 full both -> Write", word(2, 2, 5, 3));
    set_fill(1, 2, 1, 0, 1, 2); tick(); see(1, "R3 full wr only -> Read", word(2, 1, 1, 2));
    set_fill(2, 2, 0, 1, 0, 0); tick(); see(2, "R3 not after wr -> None", word(2, 0, 0, 0));
    set_fill(3, 0, 1, 1, 0, 0); tick(); see(3, "R4 lastwrite caps at Read", word(0, 1, 0, 0));
    set_fill(4, 1, 1, 1, 0, 0); tick(); see(4, "R4 alllastreads -> None", word(1, 0, 0, 0));
    set_fill(5, 3, 1, 1, 0, 0); tick(); see(5, "R4 insoftware -> None", word(3, 0, 0, 0));
  endtask

  task automatic t_evict();
    set_evc(0, 1); tick(); see(0, "R5 full evict wr -> allrd", word(1, 2, 5, 3));
    set_evc(0, 0); tick(); see(0, "R5 allrd evict rd -> soft", word(3, 2, 5, 3));
    set_evc(0, 0); tick(); see(0, "R5 soft evict unchanged", word(3, 2, 5, 3));
    set_evc(1, 0); tick(); see(1, "R5 full evict rd -> lastwr", word(0, 1, 1, 2));
    set_evc(1, 1); tick(); see(1, "R5 lastwr evict wr -> soft", word(3, 1, 1, 2));
    set_evc(3, 0); tick(); see(3, "R5 lastwr evict rd unchanged", word(0, 1, 0, 0));
    set_evc(4, 1); tick(); see(4, "R5 allrd evict wr unchanged", word(1, 0, 0, 0));
  endtask

  task automatic t_remote();
    set_fill(6, 2, 1, 1, 0, 0); tick(); see(6, "R3 fill for remote", word(2, 2, 0, 0));
    set_rmt(6, 0); tick(); see(6, "R6 rmt rd W->R", word(2, 1, 0, 0));
    set_rmt(6, 0); tick(); see(6, "R6 rmt rd keeps R", word(2, 1, 0, 0));
    set_rmt(6, 1); tick(); see(6, "R6 rmt wr -> None", word(2, 0, 0, 0));
    set_rmt(6, 0); tick(); see(6, "R6 rmt rd keeps None", word(2, 0, 0, 0));
  endtask

  task automatic t_filter();
    set_fill(2, 2, 1, 1, 0, 0); tick();
    set_acc(2, 0, 7); tick(); chk_resp("R8 read with W", 1);
    see(2, "R7 read clock stored", word(2, 2, 7, 0));
    set_acc(2, 1, 9); tick(); chk_resp("R8 write with W", 1);
    see(2, "R7 write clock stored", word(2, 2, 7, 9));
    set_fill(3, 0, 1, 1, 4, 4); tick();
    set_acc(3, 0, 11); tick(); chk_resp("R8 read with R", 1);
    set_acc(3, 1, 12); tick(); chk_resp("R8 write with R", 0);
    see(3, "R7 write sets Everything", word(2, 1, 11, 12));
    set_fill(4, 1, 0, 0, 0, 0); tick();
    set_acc(4, 0, 3); tick(); chk_resp("R8 read with None", 0);
    see(4, "R7 read on failed filter", word(1, 0, 3, 0));
    tick(); chk("R11 idle resp low", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_order();
    set_fill(5, 2, 1, 1, 0, 0); tick();
    set_rmt(5, 0); set_acc(5, 1, 20); tick(); chk_resp("R9 remote before local", 0);
    see(5, "R9 remote then local word", word(2, 1, 0, 20));
    set_fill(6, 2, 1, 1, 0, 0); tick();
    set_evc(6, 1); set_rmt(6, 0); set_acc(6, 1, 21); tick();
    chk_resp("R9 evict+remote+local", 0);
    see(6, "R9 evict then local status", word(2, 1, 0, 21));
    set_fill(7, 2, 1, 1, 2, 2); set_acc(7, 1, 30); tick();
    chk_resp("R9 fill before local", 1);
    see(7, "R9 fill then local word", word(2, 2, 2, 30));
  endtask

  task automatic t_back2back();
    set_acc(7, 0, 1); tick(); chk_resp("R11 first of pair", 1);
    set_acc(4, 1, 2); tick(); chk_resp("R11 second of pair", 0);
    tick(); chk("R11 pair ends", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_addr();
    md_base = 32'h1000_0000; md_data_addr = 32'h34; #1;
    chk("R10 base+2x", md_addr, 32'h1000_0068);
    md_data_addr = 32'h0; #1;
    chk("R10 zero addr", md_addr, 32'h1000_0000);
    md_base = 32'h0; md_data_addr = 32'h8000_0001; #1;
    chk("R10 wraps", md_addr, 32'h0000_0002);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    clear_in();
    view_byte = 0; md_base = 0; md_data_addr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_evict();
    t_remote();
    t_filter();
    t_order();
    t_back2back();
    t_addr();
    finish_run();
  end
endmodule